// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is an 8-bit down-counter fed through a 7-bit prescaler. A two-bit source field chooses what advances the prescaler: the chip's internal clock enable, that enable ANDed with an external timer pin, nothing at all, or the rising edges of the pin alone. The asynchronous pin passes through a two-flop synchronizer before it is used. A three-bit tap code picks a divide-by-2^n output of the prescaler, and each tap pulse moves the counter down by one.

When the counter steps down from zero it wraps to all ones and raises a sticky overflow flag. The flag drives the interrupt request unless the mask bit is set. Software clears the flag by writing a 0 to it. Software can also clear the prescaler with a self-clearing control bit, so that the next count period is full length. Nothing in the block depends on the processor clock being stopped, so counting continues while the core sleeps.

Top module: `pdt_timer`

## Requirements
- R1: After reset the counter reads 0xFF, the control register reads 0x44 (flag 0, mask 1, source 00, tap code 100) and the interrupt request is low.
- R2: With source 00 and tap code n, the counter decreases by exactly one for every 2^n cycles in which the clock enable is high, counted from a cleared prescaler.
- R3: With source 01, only clock-enable cycles in which the synchronized pin is high advance the prescaler. While the pin is low the counter holds.
- R4: With source 10, the counter holds whatever the clock enable and the pin do.
- R5: With source 11, each rising edge of the pin, after two synchronizing flops, counts as one prescaler input, and the clock enable has no effect.
- R6: A decrement from 0x00 gives 0xFF and sets the flag (control bit 7) at the same clock edge.
- R7: A control write with bit 7 = 0 clears the flag, and a control write with bit 7 = 1 leaves it unchanged. If an underflow falls in the same cycle as a clearing write, the flag ends up set.
- R8: A control write with bit 3 = 1 clears the prescaler, and the prescaler input of that cycle is dropped. Bit 3 always reads as 0.
- R9: The interrupt request is high exactly when the flag is 1 and the mask (control bit 6) is 0.
- R10: A data-register write loads the counter. If a tap pulse arrives in the same cycle, the write wins and the flag is not set.
- R11: A control write stores the mask from bit 6, the source from bits 5:4 and the tap code from bits 2:0, and these read back in the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Internal timer clock enable, one cycle per internal tick |
| tmr_pin | input | 1 | Asynchronous external timer pin |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = data register, 1 = control register |
| wr_data | input | 8 | Write data |
| cnt_o | output | 8 | Counter value (data register read) |
| ctl_o | output | 8 | Control register read value |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in one cycle. The first is a counter underflow together with a software write that clears the flag. The bench arranges this by loading zero with tap code 0 and raising the clock enable in the same cycle as the clearing control write. It then expects the counter to read 0xFF and the flag to stay set. The second is a data-register load together with a tap pulse. The bench expects the loaded value, not the decremented one, to appear, with the flag still clear.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
    typedef enum logic [1:0] {
        SRC_INT   = 2'b00,
        SRC_GATED = 2'b01,
        SRC_OFF   = 2'b10,
        SRC_PIN   = 2'b11
    } src_e;

    // control register fields; bit 3 is the write-only prescaler clear
    typedef struct packed {
        logic       flag;   // bit 7
        logic       mask;   // bit 6
        src_e       src;    // bits 5:4
        logic [2:0] psel;   // bits 2:0
    } ctl_t;

    localparam ctl_t CTL_RST = '{flag: 1'b0, mask: 1'b1, src: SRC_INT, psel: 3'b100};
endpackage

// File: rtl/pdt_pin_sync.sv
module pdt_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], pin_i};
        st_d.last = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.sh[STAGES-1];
    assign rise_o  = st_q.sh[STAGES-1] & ~st_q.last;

    // R5: an edge reported now was present on the pin two samples ago
    p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> $past(pin_i, 2));
endmodule

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
    parameter int PSC_W = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_i,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } st_t;

    st_t              st_d, st_q;
    logic [PSC_W:0]   low_mask;
    logic             full;

    always_comb begin
        low_mask = ({{PSC_W{1'b0}}, 1'b1} << sel_i) - 1'b1;
        full     = &(st_q.cnt | ~low_mask[PSC_W-1:0]);
        tick_o   = pulse_i & ~clr_i & full;
        st_d     = st_q;
        if (clr_i)        st_d.cnt = '0;
        else if (pulse_i) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a software clear empties the prescaler at the next edge
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> st_q.cnt == '0);
    // R2: with no input pulse the prescaler holds unless cleared
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_i && !clr_i) |=> $stable(st_q.cnt));
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
    import pdt_pkg::*;
#(
    parameter int CNT_W = 8,   // at most 8, loaded from the write bus
    parameter int PSC_W = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             tmr_pin,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    output logic [CNT_W-1:0] cnt_o,
    output logic [7:0]       ctl_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] CNT_ONES = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        ctl_t             ctl;
    } st_t;

    st_t  st_d, st_q;
    logic pin_lvl, pin_rise;
    logic data_wr, ctl_wr, psc_clr, pulse, tick, flag_set;

    pdt_pin_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (tmr_pin),
        .level_o (pin_lvl),
        .rise_o  (pin_rise)
    );

    pdt_prescaler #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (pulse),
        .clr_i   (psc_clr),
        .sel_i   (st_q.ctl.psel[SEL_W-1:0]),
        .tick_o  (tick)
    );

    always_comb begin
        data_wr = wr_en & ~wr_sel;
        ctl_wr  = wr_en &  wr_sel;
        psc_clr = ctl_wr & wr_data[3];

        unique case (st_q.ctl.src)
            SRC_INT:   pulse = clk_en;
            SRC_GATED: pulse = clk_en & pin_lvl;
            SRC_OFF:   pulse = 1'b0;
            SRC_PIN:   pulse = pin_rise;
            default:   pulse = 1'b0;
        endcase

        flag_set = tick & ~data_wr & (st_q.cnt == '0);

        st_d = st_q;
        if (data_wr)   st_d.cnt = wr_data[CNT_W-1:0];
        else if (tick) st_d.cnt = st_q.cnt - 1'b1;

        if (ctl_wr) begin
            st_d.ctl.mask = wr_data[6];
            st_d.ctl.src  = src_e'(wr_data[5:4]);
            st_d.ctl.psel = wr_data[2:0];
            st_d.ctl.flag = (st_q.ctl.flag & wr_data[7]) | flag_set;
        end else begin
            st_d.ctl.flag = st_q.ctl.flag | flag_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: CNT_ONES, ctl: CTL_RST};
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign ctl_o = {st_q.ctl.flag, st_q.ctl.mask, st_q.ctl.src, 1'b0, st_q.ctl.psel};
    assign irq_o = st_q.ctl.flag & ~st_q.ctl.mask;

    // R6: a tap pulse at zero wraps to all ones and raises the flag
    p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !data_wr && cnt_o == '0) |=> (cnt_o == CNT_ONES && ctl_o[7]));
    // R2: a tap pulse above zero takes exactly one off the counter
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !data_wr && cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1'b1);
    // R4: with no tap pulse and no load the counter holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !data_wr) |=> $stable(cnt_o));
    // R7: the flag stays set until a write with bit 7 low
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o[7] && !(ctl_wr && !wr_data[7])) |=> ctl_o[7]);
    // R10: a data write is seen on the counter at the next edge
    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> cnt_o == $past(wr_data[CNT_W-1:0]));
    // R8: the prescaler clear bit never reads back as 1
    p_clr_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_o[3]);
endmodule

// File: tb/pdt_timer_tb.sv
module pdt_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic       tmr_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] cnt_o, ctl_o;
    logic       irq_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .tmr_pin(tmr_pin),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cnt_o(cnt_o), .ctl_o(ctl_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulses(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            clk_en = 1'b1;
        end
        @(negedge clk);
        clk_en = 1'b0;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic pin_edges(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); tmr_pin = 1'b1;
            idle(2);
            tmr_pin = 1'b0;
            idle(2);
        end
        idle(4);
    endtask

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 cnt", cnt_o, 8'hFF);
        chk("R1 ctl", ctl_o, 8'h44);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);

        // R2/R8/R11 sweep over every tap code
        for (int n = 0; n < 8; n++) begin
            wr(1'b1, 8'h48 | 8'(n));
            chk("R8 R11 ctl readback", ctl_o, 8'h40 | 8'(n));
            wr(1'b0, 8'd200);
            pulses((4 << n) - 1);
            chk("R2 short of tap", cnt_o, 8'd197);
            pulses(1);
            chk("R2 tap reached", cnt_o, 8'd196);
            chk("R2 no flag", {7'd0, ctl_o[7]}, 8'h00);
        end

        // R8 prescaler clear restarts a full period (tap code 3)
        wr(1'b1, 8'h4B);
        wr(1'b0, 8'd50);
        pulses(5);
        wr(1'b1, 8'h4B);
        pulses(7);
        chk("R8 truncated period dropped", cnt_o, 8'd50);
        pulses(1);
        chk("R8 full period", cnt_o, 8'd49);

        // R6 wrap and flag, R9 masking
        wr(1'b1, 8'h48);
        wr(1'b0, 8'd2);
        pulses(2);
        chk("R6 at zero", cnt_o, 8'h00);
        chk("R6 flag clear before wrap", {7'd0, ctl_o[7]}, 8'h00);
        pulses(1);
        chk("R6 wrap", cnt_o, 8'hFF);
        chk("R6 flag", {7'd0, ctl_o[7]}, 8'h01);
        chk("R9 masked", {7'd0, irq_o}, 8'h00);
        wr(1'b1, 8'h80);
        chk("R7 write one keeps flag", {7'd0, ctl_o[7]}, 8'h01);
        chk("R9 unmasked irq", {7'd0, irq_o}, 8'h01);
        wr(1'b1, 8'h00);
        chk("R7 write zero clears", {7'd0, ctl_o[7]}, 8'h00);
        chk("R9 irq drops", {7'd0, irq_o}, 8'h00);

        // R7 underflow and clearing write in the same cycle
        wr(1'b1, 8'h80);
        wr(1'b1, 8'h48);
        wr(1'b0, 8'h00);
        @(negedge clk);
        clk_en = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h40;
        @(negedge clk);
        clk_en = 1'b0; wr_en = 1'b0;
        chk("R7 set wins over clear", {7'd0, ctl_o[7]}, 8'h01);
        chk("R6 wrap during clear", cnt_o, 8'hFF);

        // R10 load wins over a tap pulse
        wr(1'b1, 8'h48);
        @(negedge clk);
        clk_en = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h00;
        @(negedge clk);
        clk_en = 1'b0; wr_en = 1'b0;
        chk("R10 load wins", cnt_o, 8'h00);
        chk("R10 no flag", {7'd0, ctl_o[7]}, 8'h00);
        @(negedge clk);
        clk_en = 1'b1; wr_en = 1'b1; wr_data = 8'h55;
        @(negedge clk);
        clk_en = 1'b0; wr_en = 1'b0;
        chk("R10 load at zero, no underflow", cnt_o, 8'h55);
        chk("R10 flag untouched", {7'd0, ctl_o[7]}, 8'h00);

        // R4 no-clock source
        wr(1'b1, 8'h68);
        chk("R11 source 10", ctl_o, 8'h60);
        tmr_pin = 1'b1;
        pulses(20);
        tmr_pin = 1'b0;
        pin_edges(3);
        chk("R4 holds", cnt_o, 8'h55);

        // R3 gated source
        wr(1'b1, 8'h58);
        wr(1'b0, 8'd100);
        tmr_pin = 1'b1;
        idle(4);
        pulses(10);
        chk("R3 pin high counts", cnt_o, 8'd90);
        tmr_pin = 1'b0;
        idle(4);
        pulses(10);
        chk("R3 pin low holds", cnt_o, 8'd90);

        // R5 pin-only source
        wr(1'b1, 8'h78);
        wr(1'b0, 8'd60);
        pulses(10);
        chk("R5 clock enable ignored", cnt_o, 8'd60);
        pin_edges(6);
        chk("R5 six edges", cnt_o, 8'd54);
        wr(1'b1, 8'h79);
        pin_edges(6);
        chk("R5 six edges tap 1", cnt_o, 8'd51);
        pin_edges(1);
        chk("R5 odd edge held in prescaler", cnt_o, 8'd51);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule